// File: doc/BRIEF.md
# Bus Snoop Qualification and Retry Unit

This block watches a shared address bus on behalf of a copy-back data cache. Whenever another master starts a transaction, the block decides whether the transaction has to be snooped. It qualifies a transaction when the global coherency attribute is set. It also qualifies one when a load-reserve reservation is held and the transfer type is in the write-or-kill class, even with the global attribute clear. The block always answers with an address acknowledge one cycle after the transfer start. It checks the parity of every qualified address.

A qualified address is reduced to its 32-byte line and compared in the same cycle against three things: a small direct-mapped L1 tag store, a set of outstanding line-fill entries (burst reads still waiting for data), and a set of pending write-back entries (castouts not yet granted the bus). A match in any of them raises address-retry in the acknowledge cycle. A tag hit also raises a push request (modified line) or an invalidate request (clean line) toward the cache. The request is held until the cache accepts it, and the tag state is then updated. While such a request is open, the unit cannot take another lookup, so it retries every qualified snoop.

Top module: `snoop_retry_unit`

## Requirements
- R1: `aack_o` is high in the cycle after every cycle in which `ts_i` is high, whether or not the transaction is snooped, and is low otherwise.
- R2: A transaction is snooped only when `ts_i` is high and either `gbl_i` is high, or `resv_i` is high and the transfer type is in the write-or-kill class (bit 3 of `tt_i` set). A transaction that is not snooped never causes retry, a parity error or a request.
- R3: For a snooped transaction, `apar_i[k]` must give odd parity over byte k of `addr_i` (`addr_i[8k+7:8k]` plus `apar_i[k]` has an odd number of ones). A mismatch drives `perr_o` high in the acknowledge cycle. Parity is not checked for transactions that are not snooped.
- R4: A snooped line that is valid in the tag store (set index = line bits [2:0]) raises `artry_o`. It also raises `push_req_o` if the line is modified, or `inv_req_o` if it is clean, with `req_line_o` giving the line (address bits [31:5]). The request holds until `req_ack_i` is seen.
- R5: When a request is accepted, the line is invalidated. The one exception is a push caused by a transfer outside the write-or-kill class: that line stays valid and becomes clean.
- R6: A snooped line that matches a valid line-fill entry raises `artry_o` until that entry is cleared by `fill_last_i`. After the clear, the line no longer causes retry.
- R7: A snooped line that matches a write-back entry raises `artry_o` until `wb_grant_i` clears that entry. After the grant, the line no longer causes retry.
- R8: While a push or invalidate request is pending, every snooped transaction is retried and no new request is raised.
- R9: All comparisons use address bits [31:5] only. Any offset inside a 32-byte line matches that line.
- R10: `artry_o` and `perr_o` are single-cycle pulses that appear only in a cycle where `aack_o` is high.
- R11: After reset, all outputs are low, and the tag store, fill entries and write-back entries are all empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ts_i | input | 1 | Transfer start from another master |
| gbl_i | input | 1 | Global (coherency required) attribute |
| tt_i | input | 5 | Transfer type; bit 3 set marks write-or-kill |
| resv_i | input | 1 | Load-reserve reservation active |
| addr_i | input | 32 | Transaction address |
| apar_i | input | 4 | Odd parity, one bit per address byte |
| tag_wr_i | input | 1 | Install a line into the tag store |
| tag_wr_line_i | input | 27 | Line to install |
| tag_wr_mod_i | input | 1 | Installed line is modified |
| fill_set_i | input | 1 | Open a line-fill entry |
| fill_set_slot_i | input | 2 | Fill slot to open |
| fill_set_line_i | input | 27 | Line being filled |
| fill_last_i | input | 1 | Last data beat of a fill received |
| fill_last_slot_i | input | 2 | Fill slot to close |
| wb_set_i | input | 1 | Queue a write-back entry |
| wb_set_slot_i | input | 2 | Write-back slot to open |
| wb_set_line_i | input | 27 | Line queued for write-back |
| wb_grant_i | input | 1 | Bus granted to a write-back |
| wb_grant_slot_i | input | 2 | Write-back slot granted |
| req_ack_i | input | 1 | Cache accepts the pending request |
| aack_o | output | 1 | Address acknowledge |
| artry_o | output | 1 | Address retry |
| perr_o | output | 1 | Address parity error on a snooped transaction |
| push_req_o | output | 1 | Push modified line request |
| inv_req_o | output | 1 | Invalidate line request |
| req_line_o | output | 27 | Line of the pending request |

## Verification
On every cycle the assertions check the following. Each transfer start is acknowledged. Retry and parity error occur only alongside an acknowledge. At most one request kind is raised at a time, and an unaccepted request holds its line. A pending request forces retry. A clear or grant empties its slot. An accepted request leaves the tag in the required state. Only the bench scenarios can show the rest: the qualification rule, including the reservation path with the global attribute off; which structure matched; the difference between a fill before and after its last beat and a write-back before and after its grant; and the resulting tag state, seen through later snoops.

// File: rtl/snoop_pkg.sv
// Package: shared types for the snoop qualification and retry unit.
// Assumes: one open cache request at a time, tracked by kind.
package snoop_pkg;
    typedef enum logic {
        KIND_INV  = 1'b0,
        KIND_PUSH = 1'b1
    } snoop_kind_t;
endpackage

// File: rtl/snoop_qual.sv
// Module: snoop_qual
// Decides whether a transfer start must be snooped, checks the per-byte
// odd address parity and reduces the address to its line number.
// Assumes: purely combinational; ADDR_W is a multiple of 8.
module snoop_qual #(
    parameter int ADDR_W   = 32,
    parameter int OFS_W    = 5,
    parameter int TT_W     = 5,
    parameter logic [TT_W-1:0] WK_MASK  = 5'b01000,
    parameter logic [TT_W-1:0] WK_MATCH = 5'b01000,
    parameter int LINE_W   = ADDR_W - OFS_W
) (
    input  logic                  ts_i,
    input  logic                  gbl_i,
    input  logic [TT_W-1:0]       tt_i,
    input  logic                  resv_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [ADDR_W/8-1:0]   apar_i,
    output logic                  qual_o,
    output logic                  wk_o,
    output logic                  par_bad_o,
    output logic [LINE_W-1:0]     line_o
);
    localparam int NBYTES = ADDR_W / 8;

    logic [NBYTES-1:0] byte_bad;

    // Per-byte odd parity: a byte is bad when its bits plus parity are even.
    genvar b;
    generate
        for (b = 0; b < NBYTES; b++) begin : g_par
            assign byte_bad[b] = ~(^{addr_i[8*b +: 8], apar_i[b]});
        end
    endgenerate

    // Qualification: global attribute, or reservation plus write/kill type.
    always_comb begin
        wk_o      = ((tt_i & WK_MASK) == WK_MATCH);
        qual_o    = ts_i && (gbl_i || (resv_i && wk_o));
        par_bad_o = |byte_bad;
        line_o    = addr_i[ADDR_W-1:OFS_W];
    end
endmodule

// File: rtl/snoop_tags.sv
// Module: snoop_tags
// Direct-mapped L1 data tag store holding valid, modified and full line.
// Answers a snoop lookup combinationally and applies install and snoop
// outcome updates. Assumes: an install in the same cycle as an update to
// the same set wins.
module snoop_tags #(
    parameter int LINE_W = 27,
    parameter int SETS   = 8,
    parameter int IDX_W  = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] look_line_i,
    output logic              hit_o,
    output logic              hit_mod_o,
    input  logic              wr_i,
    input  logic [LINE_W-1:0] wr_line_i,
    input  logic              wr_mod_i,
    input  logic              upd_i,
    input  logic [IDX_W-1:0]  upd_idx_i,
    input  logic              upd_keep_i
);
    logic [SETS-1:0]   vld_q;
    logic [SETS-1:0]   mod_q;
    logic [LINE_W-1:0] line_q [SETS];
    logic [IDX_W-1:0]  look_idx;
    logic [IDX_W-1:0]  wr_idx;

    // Set selection for lookup and install.
    always_comb begin
        look_idx  = look_line_i[IDX_W-1:0];
        wr_idx    = wr_line_i[IDX_W-1:0];
        hit_o     = vld_q[look_idx] && (line_q[look_idx] == look_line_i);
        hit_mod_o = mod_q[look_idx];
    end

    // Tag state: snoop outcome first, then install so that install wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            mod_q <= '0;
            for (int s = 0; s < SETS; s++) line_q[s] <= '0;
        end else begin
            if (upd_i) begin
                mod_q[upd_idx_i] <= 1'b0;
                if (!upd_keep_i) vld_q[upd_idx_i] <= 1'b0;
            end
            if (wr_i) begin
                vld_q[wr_idx]  <= 1'b1;
                mod_q[wr_idx]  <= wr_mod_i;
                line_q[wr_idx] <= wr_line_i;
            end
        end
    end

    // R5: an accepted invalidating outcome leaves the set invalid.
    p_inval_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !upd_keep_i && !(wr_i && wr_idx == upd_idx_i))
        |=> !vld_q[$past(upd_idx_i)]);

    // R5: an accepted keeping outcome leaves the set clean.
    p_clean_on_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && upd_keep_i && !(wr_i && wr_idx == upd_idx_i))
        |=> !mod_q[$past(upd_idx_i)]);
endmodule

// File: rtl/snoop_line_queue.sv
// Module: snoop_line_queue
// A small set of slot-addressed line entries (used for outstanding fills
// and for pending write-backs). Reports whether a looked-up line matches
// any valid entry. Assumes: the caller picks slots; a set and a clear of
// the same slot in one cycle leave the slot set.
module snoop_line_queue #(
    parameter int LINE_W = 27,
    parameter int DEPTH  = 4,
    parameter int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [SLOT_W-1:0] set_slot_i,
    input  logic [LINE_W-1:0] set_line_i,
    input  logic              clr_i,
    input  logic [SLOT_W-1:0] clr_slot_i,
    input  logic [LINE_W-1:0] look_line_i,
    output logic              match_o
);
    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] hit_vec;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_ent
            logic              vld;
            logic [LINE_W-1:0] line;

            // Entry state: clear first, then set.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld  <= 1'b0;
                    line <= '0;
                end else begin
                    if (clr_i && clr_slot_i == SLOT_W'(g)) vld <= 1'b0;
                    if (set_i && set_slot_i == SLOT_W'(g)) begin
                        vld  <= 1'b1;
                        line <= set_line_i;
                    end
                end
            end

            assign vld_vec[g] = vld;
            assign hit_vec[g] = vld && (line == look_line_i);
        end
    endgenerate

    // Any valid entry on the looked-up line.
    assign match_o = |hit_vec;

    // R6 (and R7 for write-backs): a clear empties its slot.
    p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(set_i && set_slot_i == clr_slot_i))
        |=> !vld_vec[$past(clr_slot_i)]);

    // R6: a set fills its slot.
    p_set_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> vld_vec[$past(set_slot_i)]);
endmodule

// File: rtl/snoop_retry_unit.sv
// Module: snoop_retry_unit (top)
// Qualifies bus transactions of other masters for snooping, looks the
// line up in the tag store, the outstanding fills and the queued
// write-backs, and answers one cycle after transfer start with acknowledge,
// retry and parity error. A tag hit opens one push or invalidate request
// toward the cache. Assumes: one open request at a time; a snoop that
// arrives while a request is open is retried as a resource conflict.
module snoop_retry_unit
    import snoop_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int OFS_W   = 5,
    parameter int TT_W    = 5,
    parameter int SETS    = 8,
    parameter int N_FILL  = 4,
    parameter int N_WB    = 4,
    parameter int LINE_W  = ADDR_W - OFS_W,
    parameter int FILL_SW = $clog2(N_FILL),
    parameter int WB_SW   = $clog2(N_WB)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ts_i,
    input  logic                 gbl_i,
    input  logic [TT_W-1:0]      tt_i,
    input  logic                 resv_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [ADDR_W/8-1:0]  apar_i,
    input  logic                 tag_wr_i,
    input  logic [LINE_W-1:0]    tag_wr_line_i,
    input  logic                 tag_wr_mod_i,
    input  logic                 fill_set_i,
    input  logic [FILL_SW-1:0]   fill_set_slot_i,
    input  logic [LINE_W-1:0]    fill_set_line_i,
    input  logic                 fill_last_i,
    input  logic [FILL_SW-1:0]   fill_last_slot_i,
    input  logic                 wb_set_i,
    input  logic [WB_SW-1:0]     wb_set_slot_i,
    input  logic [LINE_W-1:0]    wb_set_line_i,
    input  logic                 wb_grant_i,
    input  logic [WB_SW-1:0]     wb_grant_slot_i,
    input  logic                 req_ack_i,
    output logic                 aack_o,
    output logic                 artry_o,
    output logic                 perr_o,
    output logic                 push_req_o,
    output logic                 inv_req_o,
    output logic [LINE_W-1:0]    req_line_o
);
    localparam int IDX_W = $clog2(SETS);

    logic              qual, wk, par_bad;
    logic [LINE_W-1:0] line;
    logic              tag_hit, tag_mod, fill_hit, wb_hit;
    logic              look, retry_d, new_req, upd, upd_keep;

    logic              aack_q, artry_q, perr_q, pend_q, wk_q;
    snoop_kind_t       kind_q;
    logic [LINE_W-1:0] line_q;

    snoop_qual #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .TT_W   (TT_W),
        .LINE_W (LINE_W)
    ) u_qual (
        .ts_i      (ts_i),
        .gbl_i     (gbl_i),
        .tt_i      (tt_i),
        .resv_i    (resv_i),
        .addr_i    (addr_i),
        .apar_i    (apar_i),
        .qual_o    (qual),
        .wk_o      (wk),
        .par_bad_o (par_bad),
        .line_o    (line)
    );

    snoop_tags #(
        .LINE_W (LINE_W),
        .SETS   (SETS)
    ) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_line_i (line),
        .hit_o       (tag_hit),
        .hit_mod_o   (tag_mod),
        .wr_i        (tag_wr_i),
        .wr_line_i   (tag_wr_line_i),
        .wr_mod_i    (tag_wr_mod_i),
        .upd_i       (upd),
        .upd_idx_i   (line_q[IDX_W-1:0]),
        .upd_keep_i  (upd_keep)
    );

    snoop_line_queue #(
        .LINE_W (LINE_W),
        .DEPTH  (N_FILL)
    ) u_fill (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (fill_set_i),
        .set_slot_i  (fill_set_slot_i),
        .set_line_i  (fill_set_line_i),
        .clr_i       (fill_last_i),
        .clr_slot_i  (fill_last_slot_i),
        .look_line_i (line),
        .match_o     (fill_hit)
    );

    snoop_line_queue #(
        .LINE_W (LINE_W),
        .DEPTH  (N_WB)
    ) u_wb (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (wb_set_i),
        .set_slot_i  (wb_set_slot_i),
        .set_line_i  (wb_set_line_i),
        .clr_i       (wb_grant_i),
        .clr_slot_i  (wb_grant_slot_i),
        .look_line_i (line),
        .match_o     (wb_hit)
    );

    // Snoop decision: a conflict retries, otherwise any match retries.
    always_comb begin
        look     = qual && !pend_q;
        retry_d  = (qual && pend_q) || (look && (tag_hit || fill_hit || wb_hit));
        new_req  = look && tag_hit;
        upd      = pend_q && req_ack_i;
        upd_keep = (kind_q == KIND_PUSH) && !wk_q;
    end

    // Response stage and the single open cache request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aack_q  <= 1'b0;
            artry_q <= 1'b0;
            perr_q  <= 1'b0;
            pend_q  <= 1'b0;
            wk_q    <= 1'b0;
            kind_q  <= KIND_INV;
            line_q  <= '0;
        end else begin
            aack_q  <= ts_i;
            artry_q <= retry_d;
            perr_q  <= qual && par_bad;
            if (upd) pend_q <= 1'b0;
            if (new_req) begin
                pend_q <= 1'b1;
                kind_q <= tag_mod ? KIND_PUSH : KIND_INV;
                wk_q   <= wk;
                line_q <= line;
            end
        end
    end

    assign aack_o     = aack_q;
    assign artry_o    = artry_q;
    assign perr_o     = perr_q;
    assign push_req_o = pend_q && (kind_q == KIND_PUSH);
    assign inv_req_o  = pend_q && (kind_q == KIND_INV);
    assign req_line_o = line_q;

    // R1: every transfer start is acknowledged in the next cycle.
    p_ack_follows_ts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ts_i |=> aack_o);

    // R10: retry only together with acknowledge.
    p_retry_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        artry_o |-> aack_o);

    // R3: parity error only together with acknowledge.
    p_perr_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> aack_o);

    // R4: never both request kinds at once.
    p_one_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_req_o, inv_req_o}));

    // R4: an unaccepted request keeps its kind and line.
    p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_req_o || inv_req_o) && !req_ack_i)
        |=> ((push_req_o || inv_req_o) && $stable(req_line_o)
             && $stable(push_req_o)));

    // R8: a global snoop during an open request is retried.
    p_pending_retries_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_req_o || inv_req_o) && ts_i && gbl_i) |=> artry_o);

    // R2: a transfer that cannot qualify causes no retry and no parity error.
    p_unqual_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_i && !gbl_i && !resv_i) |=> (!artry_o && !perr_o));
endmodule

// File: tb/snoop_retry_unit_tb.sv
`timescale 1ns/1ps
module snoop_retry_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ts = 0, gbl = 0, resv = 0;
    logic [4:0]  tt = '0;
    logic [31:0] addr = '0;
    logic [3:0]  apar = '0;
    logic        tag_wr = 0, tag_wr_mod = 0;
    logic [26:0] tag_wr_line = '0;
    logic        fill_set = 0, fill_last = 0;
    logic [1:0]  fill_set_slot = '0, fill_last_slot = '0;
    logic [26:0] fill_set_line = '0;
    logic        wb_set = 0, wb_grant = 0;
    logic [1:0]  wb_set_slot = '0, wb_grant_slot = '0;
    logic [26:0] wb_set_line = '0;
    logic        req_ack = 0;
    logic        aack, artry, perr, push_req, inv_req;
    logic [26:0] req_line;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2.5 clk = ~clk;

    snoop_retry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ts_i(ts), .gbl_i(gbl), .tt_i(tt),
        .resv_i(resv), .addr_i(addr), .apar_i(apar),
        .tag_wr_i(tag_wr), .tag_wr_line_i(tag_wr_line), .tag_wr_mod_i(tag_wr_mod),
        .fill_set_i(fill_set), .fill_set_slot_i(fill_set_slot),
        .fill_set_line_i(fill_set_line), .fill_last_i(fill_last),
        .fill_last_slot_i(fill_last_slot),
        .wb_set_i(wb_set), .wb_set_slot_i(wb_set_slot), .wb_set_line_i(wb_set_line),
        .wb_grant_i(wb_grant), .wb_grant_slot_i(wb_grant_slot),
        .req_ack_i(req_ack),
        .aack_o(aack), .artry_o(artry), .perr_o(perr),
        .push_req_o(push_req), .inv_req_o(inv_req), .req_line_o(req_line)
    );

    function automatic logic [3:0] good_par(input logic [31:0] a);
        logic [3:0] p;
        for (int k = 0; k < 4; k++) p[k] = ~^a[8*k +: 8];
        return p;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    bit          m_tv [8];
    bit          m_tm [8];
    logic [26:0] m_tl [8];
    bit          m_fv [4];
    logic [26:0] m_fl [4];
    bit          m_wv [4];
    logic [26:0] m_wl [4];
    bit          m_pend, m_push, m_wk;
    logic [26:0] m_line;
    bit          e_aack, e_artry, e_perr, e_push, e_inv;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_tv[i] = 0; m_tm[i] = 0; m_tl[i] = '0; end
            for (int i = 0; i < 4; i++) begin m_fv[i] = 0; m_wv[i] = 0; m_fl[i] = '0; m_wl[i] = '0; end
            m_pend = 0; m_push = 0; m_wk = 0; m_line = '0;
            e_aack = 0; e_artry = 0; e_perr = 0; e_push = 0; e_inv = 0;
        end else begin
            bit q, wkc, r, nreq, nmod, th, fh, wh;
            logic [26:0] ln;
            int ix;
            wkc  = tt[3];
            q    = ts && (gbl || (resv && wkc));
            ln   = addr[31:5];
            ix   = int'(ln[2:0]);
            r    = 0; nreq = 0; nmod = 0;
            if (q) begin
                if (m_pend) r = 1;
                else begin
                    th = m_tv[ix] && (m_tl[ix] == ln);
                    fh = 0; wh = 0;
                    for (int i = 0; i < 4; i++) begin
                        if (m_fv[i] && m_fl[i] == ln) fh = 1;
                        if (m_wv[i] && m_wl[i] == ln) wh = 1;
                    end
                    r = th || fh || wh;
                    nreq = th;
                    nmod = m_tm[ix];
                end
            end
            e_aack  = ts;
            e_artry = r;
            e_perr  = q && (apar != good_par(addr));
            if (m_pend && req_ack) begin
                int ui;
                ui = int'(m_line[2:0]);
                m_tm[ui] = 0;
                if (!(m_push && !m_wk)) m_tv[ui] = 0;
                m_pend = 0;
            end
            if (tag_wr) begin
                int wi;
                wi = int'(tag_wr_line[2:0]);
                m_tv[wi] = 1; m_tm[wi] = tag_wr_mod; m_tl[wi] = tag_wr_line;
            end
            if (nreq) begin
                m_pend = 1; m_push = nmod; m_wk = wkc; m_line = ln;
            end
            if (fill_last) m_fv[fill_last_slot] = 0;
            if (fill_set) begin m_fv[fill_set_slot] = 1; m_fl[fill_set_slot] = fill_set_line; end
            if (wb_grant) m_wv[wb_grant_slot] = 0;
            if (wb_set) begin m_wv[wb_set_slot] = 1; m_wl[wb_set_slot] = wb_set_line; end
            e_push = m_pend && m_push;
            e_inv  = m_pend && !m_push;
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check("R1 aack", aack, e_aack);
            check("R10 artry", artry, e_artry);
            check("R3 perr", perr, e_perr);
            check("R4 push", push_req, e_push);
            check("R4 inv", inv_req, e_inv);
            if (e_push || e_inv) check("R4 req_line", req_line, m_line);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic snoop(input logic [31:0] a, input logic g, input logic [4:0] t,
                         input logic r, input logic bad);
        @(negedge clk);
        ts = 1; gbl = g; tt = t; resv = r; addr = a;
        apar = good_par(a) ^ (bad ? 4'b0001 : 4'b0000);
        @(negedge clk);
        ts = 0; gbl = 0; resv = 0; tt = '0;
    endtask

    task automatic install(input logic [26:0] l, input logic m);
        @(negedge clk); tag_wr = 1; tag_wr_line = l; tag_wr_mod = m;
        @(negedge clk); tag_wr = 0;
    endtask

    task automatic accept();
        @(negedge clk); req_ack = 1;
        @(negedge clk); req_ack = 0;
    endtask

    localparam logic [31:0] A_ADDR = 32'h0000_0220;
    localparam logic [31:0] B_ADDR = 32'h0000_1040;
    localparam logic [31:0] C_ADDR = 32'h0000_3060;
    localparam logic [31:0] D_ADDR = 32'h0000_5080;
    localparam logic [31:0] E_ADDR = 32'h0000_70A0;

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        check("R11 aack", aack, 0);
        check("R11 artry", artry, 0);
        check("R11 push", push_req, 0);
        check("R11 inv", inv_req, 0);
        rst_n = 1;
        cmp_on = 1;
        @(negedge clk);
        // R11: empty tag store after reset
        snoop(A_ADDR, 1, 5'b00000, 0, 0);
        check("R11 empty tags no retry", artry, 0);

        install(A_ADDR[31:5], 1);
        install(B_ADDR[31:5], 0);

        snoop(A_ADDR, 0, 5'b00000, 0, 0);
        check("R1 ack on unsnooped", aack, 1);
        check("R2 no snoop without gbl/resv", artry, 0);
        snoop(A_ADDR, 0, 5'b00010, 1, 0);
        check("R2 resv with read type not snooped", artry, 0);

        snoop(A_ADDR + 32'h1C, 1, 5'b00000, 0, 0);
        check("R4 modified hit retry", artry, 1);
        check("R4 push raised", push_req, 1);
        check("R9 req_line ignores offset", req_line, A_ADDR[31:5]);
        @(negedge clk);
        check("R10 retry single pulse", artry, 0);

        snoop(B_ADDR, 1, 5'b00000, 0, 0);
        check("R8 conflict retry", artry, 1);
        check("R8 no new inv request", inv_req, 0);

        accept();
        snoop(A_ADDR, 1, 5'b00000, 0, 0);
        check("R5 read push keeps line", artry, 1);
        check("R5 kept line is clean", inv_req, 1);
        accept();
        snoop(A_ADDR, 1, 5'b00000, 0, 0);
        check("R5 invalidated line no retry", artry, 0);

        install(A_ADDR[31:5], 1);
        snoop(A_ADDR, 0, 5'b01000, 1, 0);
        check("R2 reservation write snooped", artry, 1);
        check("R2 reservation push", push_req, 1);
        accept();
        snoop(A_ADDR, 1, 5'b00000, 0, 0);
        check("R5 write push invalidates", artry, 0);

        snoop(E_ADDR, 1, 5'b00000, 0, 1);
        check("R3 parity error flagged", perr, 1);
        check("R3 parity alone no retry", artry, 0);
        snoop(E_ADDR, 0, 5'b00000, 0, 1);
        check("R3 unsnooped parity ignored", perr, 0);

        @(negedge clk); fill_set = 1; fill_set_slot = 2; fill_set_line = C_ADDR[31:5];
        @(negedge clk); fill_set = 0;
        snoop(C_ADDR + 32'h8, 1, 5'b00000, 0, 0);
        check("R6 fill collision retry", artry, 1);
        check("R6 fill collision no request", inv_req | push_req, 0);
        @(negedge clk); fill_last = 1; fill_last_slot = 2;
        @(negedge clk); fill_last = 0;
        snoop(C_ADDR, 1, 5'b00000, 0, 0);
        check("R6 after last beat no retry", artry, 0);

        @(negedge clk); wb_set = 1; wb_set_slot = 1; wb_set_line = D_ADDR[31:5];
        @(negedge clk); wb_set = 0;
        snoop(D_ADDR + 32'h4, 1, 5'b01000, 0, 0);
        check("R7 write-back collision retry", artry, 1);
        @(negedge clk); wb_grant = 1; wb_grant_slot = 1;
        @(negedge clk); wb_grant = 0;
        snoop(D_ADDR, 1, 5'b01000, 0, 0);
        check("R7 granted write-back no retry", artry, 0);

        // R1: back-to-back transfer starts
        @(negedge clk); ts = 1; addr = B_ADDR; apar = good_par(B_ADDR);
        @(negedge clk); check("R1 first of pair", aack, 1);
        @(negedge clk); ts = 0; check("R1 second of pair", aack, 1);
        @(negedge clk); check("R1 no ack without ts", aack, 0);

        // Random traffic compared against the model every cycle.
        for (int n = 0; n < 2000; n++) begin
            logic [26:0] pool [6];
            pool[0] = 27'h11; pool[1] = 27'h82; pool[2] = 27'h183;
            pool[3] = 27'h284; pool[4] = 27'h91; pool[5] = 27'h5;
            @(negedge clk);
            ts   = ($urandom % 3) == 0;
            gbl  = $urandom % 2;
            resv = $urandom % 2;
            tt   = 5'($urandom);
            addr = {pool[$urandom % 6], 5'($urandom)};
            apar = good_par(addr) ^ ((($urandom % 8) == 0) ? 4'b0100 : 4'b0000);
            tag_wr = ($urandom % 10) == 0;
            tag_wr_line = pool[$urandom % 6];
            tag_wr_mod = $urandom % 2;
            fill_set = ($urandom % 8) == 0;
            fill_set_slot = 2'($urandom);
            fill_set_line = pool[$urandom % 6];
            fill_last = ($urandom % 8) == 0;
            fill_last_slot = 2'($urandom);
            wb_set = ($urandom % 8) == 0;
            wb_set_slot = 2'($urandom);
            wb_set_line = pool[$urandom % 6];
            wb_grant = ($urandom % 8) == 0;
            wb_grant_slot = 2'($urandom);
            req_ack = ($urandom % 4) == 0;
        end
        @(negedge clk);
        ts = 0; tag_wr = 0; fill_set = 0; fill_last = 0; wb_set = 0; wb_grant = 0; req_ack = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule